// File: doc/BRIEF.md
# Load Switch Channel Sequencer

This block controls one channel of a power load switch and is placed once per channel. It decides when the main pass switch is on and when the output drain switch is on. When the channel is enabled, it waits out a short dead time and then closes the main switch. Turn-on is either immediate or follows a soft-start ramp of 1, 2, 4 or 8 base periods. While the ramp runs, a progress count rises evenly so that the analog ramp generator can follow it.

When the channel is disabled, the main switch opens at once. After a second dead time the output may be drained. The drain can be a timed pulse, can last for as long as the channel stays off, or can be turned off. Both dead times make sure that the two switches are never on together. Re-enabling the channel during a drain pulse cancels the pulse at once. Disabling it during a ramp aborts the ramp at once.

An undervoltage input forces both switches off and sends the sequencer back to idle. A parameter selects the channel variant whose enable is the OR of the register bit and a dedicated pin. All timing comes from the system clock through a prescaled tick. That tick restarts on every state change, so all durations are exact multiples of the tick.

Top module: `lsw_chan_seq`

## Requirements
- R1: With `ramp_en`=1, `ramp_sel` values 0, 1, 2 and 3 select ramp lengths of 1, 2, 4 and 8 times RAMP_BASE_TICKS ticks. `ramping` stays high for exactly that many ticks, starting in the same cycle in which `gate_on` rises.
- R2: `ramp_level` is 0 when the ramp starts and equals floor(256*n/total) after n ticks of the ramp. It is 255 while the main switch is fully on and 0 whenever `gate_on` is low.
- R3: With `ramp_en`=0, `gate_on` rises with `ramping` held low.
- R4: An effective enable sampled while the main switch is off raises `gate_on` exactly DT_ON_CYC cycles later. If `drain_on` was high, it drops in the cycle after that first sample.
- R5: A disable sampled while the main switch is on drops `gate_on` in the next cycle. If `drain_en`=1, `drain_on` rises DT_OFF_CYC cycles after `gate_on` drops.
- R6: With `drain_hold`=0, the drain pulse lasts exactly DIS_TICKS ticks (2.0 ms by default).
- R7: With `drain_hold`=1, `drain_on` stays high for as long as the channel remains disabled and `uvlo` is low.
- R8: With `drain_en`=0, `drain_on` never rises after a turn-off.
- R9: `gate_on` and `drain_on` are never high together. At least DT_OFF_CYC low cycles of `gate_on` come before any rise of `drain_on`, and at least DT_ON_CYC low cycles of `drain_on` come before any rise of `gate_on`.
- R10: A disable during the ramp drops `gate_on` and `ramping` together and returns `ramp_level` to 0.
- R11: An enable during a drain pulse ends the pulse at once, and the main switch follows after DT_ON_CYC cycles.
- R12: While `uvlo` is high, both outputs are low in the cycle after it is sampled and stay low, whatever the enable is. After `uvlo` is released, turn-on starts again from idle.
- R13: With HAS_PIN_EN=1, the effective enable is `chan_en` OR `aux_en`. With HAS_PIN_EN=0, `aux_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo | input | 1 | Undervoltage hold; forces both switches off |
| chan_en | input | 1 | Channel enable from the control register |
| aux_en | input | 1 | Dedicated enable pin, ORed in when HAS_PIN_EN=1 |
| ramp_en | input | 1 | Soft-start enable |
| ramp_sel | input | 2 | Ramp length select, 1/2/4/8 base periods |
| drain_en | input | 1 | Output drain enable |
| drain_hold | input | 1 | 1: drain while off; 0: timed drain pulse |
| gate_on | output | 1 | Main switch enable |
| ramping | output | 1 | Soft-start ramp in progress |
| ramp_level | output | PROG_W | Ramp progress, 0 up to all ones |
| drain_on | output | 1 | Drain switch enable |

## Verification
The assertions assume that `ramp_sel` and `ramp_en` do not change while a ramp is running, because the ramp length is read live. They also assume that all inputs are synchronous to `clk`. Under these assumptions, progress only rises during a ramp and the dead-time counters in the checker measure true gaps. The stimulus changes configuration inputs only while the channel is idle, fully on or draining, never in the middle of a ramp. It drives every input on the falling clock edge.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ON,
    ST_RAMP,
    ST_FULL,
    ST_WAIT_OFF,
    ST_DRAIN
  } lsw_state_e;

  // whole cycles covering a delay in ns, never less than one
  function automatic int cyc_from_ns(int mhz, int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lsw_tick.sv
module lsw_tick #(
  parameter int TICK_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (tick)   pre <= '0;
    else             pre <= pre + PW'(1);
  end
endmodule

// File: rtl/lsw_ramp_prog.sv
module lsw_ramp_prog #(
  parameter int PROG_W = 8,
  parameter int TW     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              full,
  input  logic              step,
  input  logic [TW-1:0]     total,
  output logic [PROG_W-1:0] prog
);
  localparam int AW = TW + 1;
  localparam logic [AW-1:0] LAP = AW'(2 ** PROG_W);

  logic [AW-1:0] acc;
  logic [AW-1:0] acc_sum;
  logic [AW-1:0] tot_ext;

  assign acc_sum = acc + LAP;
  assign tot_ext = {1'b0, total};

  // error-accumulating divider: one level step per crossing of the total
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      prog <= '0;
    end else if (full) begin
      acc  <= '0;
      prog <= '1;
    end else if (step) begin
      if (acc_sum >= tot_ext) begin
        acc <= acc_sum - tot_ext;
        if (prog != '1) prog <= prog + PROG_W'(1);
      end else begin
        acc <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/lsw_chan_seq.sv
module lsw_chan_seq
  import lsw_pkg::*;
#(
  parameter int CLK_HZ          = 10_000_000,
  parameter int TICK_NS         = 1000,
  parameter int RAMP_BASE_TICKS = 1000,
  parameter int DIS_TICKS       = 2000,
  parameter int DT_OFF_NS       = 220,
  parameter int DT_ON_NS        = 100,
  parameter int PROG_W          = 8,
  parameter bit HAS_PIN_EN      = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uvlo,
  input  logic              chan_en,
  input  logic              aux_en,
  input  logic              ramp_en,
  input  logic [1:0]        ramp_sel,
  input  logic              drain_en,
  input  logic              drain_hold,
  output logic              gate_on,
  output logic              ramping,
  output logic [PROG_W-1:0] ramp_level,
  output logic              drain_on
);
  localparam int CLK_MHZ    = CLK_HZ / 1_000_000;
  localparam int TICK_CYC   = imax(CLK_MHZ * TICK_NS / 1000, 1);
  localparam int DT_OFF_CYC = cyc_from_ns(CLK_MHZ, DT_OFF_NS);
  localparam int DT_ON_CYC  = cyc_from_ns(CLK_MHZ, DT_ON_NS);
  localparam int RAMP_MAX   = RAMP_BASE_TICKS * 8;
  localparam int CNT_MAX    = imax(imax(RAMP_MAX, DIS_TICKS), imax(DT_OFF_CYC, DT_ON_CYC));
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam logic PIN_MASK = HAS_PIN_EN;

  logic          en_eff;
  logic          tick;
  lsw_state_e    st, nxt;
  logic [CW-1:0] cnt;
  logic          cnt_inc;
  logic [CW-1:0] ramp_total;
  logic          lvl_clr, lvl_full, lvl_step;

  assign en_eff     = chan_en | (aux_en & PIN_MASK);
  assign ramp_total = CW'(RAMP_BASE_TICKS) << ramp_sel;

  lsw_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (nxt != st),
    .tick(tick)
  );

  always_comb begin
    nxt     = st;
    cnt_inc = 1'b0;
    unique case (st)
      ST_IDLE: if (en_eff) nxt = ST_WAIT_ON;
      ST_WAIT_ON: begin
        if (!en_eff)                        nxt = ST_IDLE;
        else if (cnt == CW'(DT_ON_CYC - 1)) nxt = ramp_en ? ST_RAMP : ST_FULL;
        else                                cnt_inc = 1'b1;
      end
      ST_RAMP: begin
        if (!en_eff) nxt = ST_WAIT_OFF;
        else if (tick) begin
          if (cnt == ramp_total - CW'(1)) nxt = ST_FULL;
          else                            cnt_inc = 1'b1;
        end
      end
      ST_FULL: if (!en_eff) nxt = ST_WAIT_OFF;
      ST_WAIT_OFF: begin
        if (en_eff)                          nxt = ST_WAIT_ON;
        else if (cnt == CW'(DT_OFF_CYC - 1)) nxt = drain_en ? ST_DRAIN : ST_IDLE;
        else                                 cnt_inc = 1'b1;
      end
      ST_DRAIN: begin
        if (en_eff) nxt = ST_WAIT_ON;
        else if (!drain_hold && tick) begin
          if (cnt == CW'(DIS_TICKS - 1)) nxt = ST_IDLE;
          else                           cnt_inc = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (uvlo) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      gate_on  <= 1'b0;
      ramping  <= 1'b0;
      drain_on <= 1'b0;
    end else begin
      st       <= nxt;
      cnt      <= (nxt != st) ? '0 : (cnt_inc ? cnt + CW'(1) : cnt);
      gate_on  <= (nxt == ST_RAMP) || (nxt == ST_FULL);
      ramping  <= (nxt == ST_RAMP);
      drain_on <= (nxt == ST_DRAIN);
    end
  end

  assign lvl_full = (nxt == ST_FULL);
  assign lvl_step = (st == ST_RAMP) && (nxt == ST_RAMP) && tick;
  assign lvl_clr  = !((nxt == ST_RAMP) || (nxt == ST_FULL)) ||
                    ((nxt == ST_RAMP) && (st != ST_RAMP));

  lsw_ramp_prog #(.PROG_W(PROG_W), .TW(CW)) u_prog (
    .clk  (clk),
    .rst  (rst),
    .clr  (lvl_clr),
    .full (lvl_full),
    .step (lvl_step),
    .total(ramp_total),
    .prog (ramp_level)
  );
endmodule

// File: rtl/lsw_chan_seq_chk.sv
module lsw_chan_seq_chk #(
  parameter int DT_OFF_CYC = 3,
  parameter int DT_ON_CYC  = 1,
  parameter int PROG_W     = 8,
  parameter bit HAS_PIN_EN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              uvlo,
  input logic              chan_en,
  input logic              aux_en,
  input logic              drain_en,
  input logic              drain_hold,
  input logic              gate_on,
  input logic              ramping,
  input logic [PROG_W-1:0] ramp_level,
  input logic              drain_on
);
  localparam int SAT = (DT_OFF_CYC > DT_ON_CYC) ? DT_OFF_CYC : DT_ON_CYC;
  localparam int DW  = $clog2(SAT + 1) + 1;

  logic          en_eff;
  logic [DW-1:0] gate_low, drain_low;

  assign en_eff = chan_en | (aux_en & HAS_PIN_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_low  <= DW'(SAT);
      drain_low <= DW'(SAT);
    end else begin
      if (gate_on)                  gate_low <= '0;
      else if (gate_low < DW'(SAT)) gate_low <= gate_low + DW'(1);
      if (drain_on)                  drain_low <= '0;
      else if (drain_low < DW'(SAT)) drain_low <= drain_low + DW'(1);
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(gate_on && drain_on));

  assert_off_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_on) |-> gate_low >= DW'(DT_OFF_CYC));

  assert_on_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> drain_low >= DW'(DT_ON_CYC));

  assert_uv_off_R12: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (!gate_on && !drain_on));

  assert_disable_off_R5: assert property (@(posedge clk) disable iff (rst)
    !en_eff |=> !gate_on);

  assert_drain_gated_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_on) |-> $past(drain_en));

  assert_hold_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (drain_on && drain_hold && !en_eff && !uvlo) |=> drain_on);

  assert_ramp_in_gate_R10: assert property (@(posedge clk) disable iff (rst)
    ramping |-> gate_on);

  assert_level_rises_R2: assert property (@(posedge clk) disable iff (rst)
    (ramping && $past(ramping)) |-> ramp_level >= $past(ramp_level));

  assert_level_zero_off_R2: assert property (@(posedge clk) disable iff (rst)
    !gate_on |-> ramp_level == '0);

  assert_level_full_R2: assert property (@(posedge clk) disable iff (rst)
    (gate_on && !ramping) |-> ramp_level == '1);
endmodule

bind lsw_chan_seq lsw_chan_seq_chk #(
  .DT_OFF_CYC(DT_OFF_CYC),
  .DT_ON_CYC (DT_ON_CYC),
  .PROG_W    (PROG_W),
  .HAS_PIN_EN(HAS_PIN_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .uvlo      (uvlo),
  .chan_en   (chan_en),
  .aux_en    (aux_en),
  .drain_en  (drain_en),
  .drain_hold(drain_hold),
  .gate_on   (gate_on),
  .ramping   (ramping),
  .ramp_level(ramp_level),
  .drain_on  (drain_on)
);

// File: tb/sim_lsw_chan_seq.sv
module sim_lsw_chan_seq;
  localparam int TCK   = 2;
  localparam int DTON  = 25;
  localparam int DTOFF = 55;
  localparam int BASE  = 256;
  localparam int DIS   = 300;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, uvlo, chan_en, aux_en, ramp_en, drain_en, drain_hold;
  logic [1:0] ramp_sel;
  logic       gate_on, ramping, drain_on;
  logic [7:0] ramp_level;

  lsw_chan_seq #(
    .CLK_HZ(250_000_000), .TICK_NS(8), .RAMP_BASE_TICKS(BASE), .DIS_TICKS(DIS),
    .DT_OFF_NS(220), .DT_ON_NS(100), .PROG_W(8), .HAS_PIN_EN(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .uvlo(uvlo), .chan_en(chan_en), .aux_en(aux_en),
    .ramp_en(ramp_en), .ramp_sel(ramp_sel), .drain_en(drain_en), .drain_hold(drain_hold),
    .gate_on(gate_on), .ramping(ramping), .ramp_level(ramp_level), .drain_on(drain_on)
  );

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int n_cmp = 0, n_bad = 0;

  typedef struct {
    int         cyc;
    logic [2:0] v;
    string      req;
  } ev_t;
  ev_t q[$];

  logic       mon_on = 1'b0;
  logic [2:0] last_v, cur_v;
  ev_t        got;

  // driver side: expected output snapshot {gate, ramping, drain} at an edge
  task automatic expect_ev(int cyc, logic g, logic r, logic d, string req);
    ev_t e;
    e.cyc = cyc; e.v = {g, r, d}; e.req = req;
    q.push_back(e);
  endtask

  // monitor side: every output change must match the queue head
  always @(negedge clk) begin
    if (mon_on) begin
      cur_v = {gate_on, ramping, drain_on};
      if (cur_v !== last_v) begin
        n_cmp++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected change: actual %b at edge %0d, expected none", cur_v, edge_n);
        end else begin
          got = q.pop_front();
          if (got.cyc != edge_n || got.v !== cur_v) begin
            n_bad++;
            $display("FAIL %s: actual %b at edge %0d, expected %b at edge %0d",
                     got.req, cur_v, edge_n, got.v, got.cyc);
          end
        end
        last_v = cur_v;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(int k);
    while (edge_n < k) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int e, m, d, u, tot, n;
    rst = 1; uvlo = 0; chan_en = 0; aux_en = 0; ramp_en = 0; ramp_sel = 0;
    drain_en = 0; drain_hold = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2", ramp_level, 0);
    check("R9", {gate_on, drain_on}, 0);
    last_v = 3'b000;
    mon_on = 1'b1;

    // R1, R2, R8: each ramp length, turn-off with drain disabled
    for (int s = 0; s < 4; s++) begin
      ramp_en = 1; ramp_sel = 2'(s); drain_en = 0; chan_en = 1;
      e = edge_n + 1; m = e + DTON; tot = BASE << s;
      expect_ev(m, 1, 1, 0, "R4");
      expect_ev(m + tot * TCK, 1, 0, 0, "R1");
      n = tot / 3;
      wait_edge(m + n * TCK);
      check("R2", ramp_level, (256 * n) / tot);
      wait_edge(m + tot * TCK + 2);
      check("R2", ramp_level, 255);
      chan_en = 0; d = edge_n + 1;
      expect_ev(d, 0, 0, 0, "R8");
      wait_edge(d + DTOFF + DIS * TCK + 20);
      check("R8", drain_on, 0);
      check("R2", ramp_level, 0);
    end

    // R3, R5, R6: no ramp, timed drain pulse
    ramp_en = 0; chan_en = 1; e = edge_n + 1;
    expect_ev(e + DTON, 1, 0, 0, "R3");
    wait_edge(e + DTON + 3);
    check("R3", ramp_level, 255);
    drain_en = 1; drain_hold = 0; chan_en = 0; d = edge_n + 1;
    expect_ev(d, 0, 0, 0, "R5");
    expect_ev(d + DTOFF, 0, 0, 1, "R5");
    expect_ev(d + DTOFF + DIS * TCK, 0, 0, 0, "R6");
    wait_edge(d + DTOFF + DIS * TCK + 10);

    // R11: re-enable inside the pulse
    chan_en = 1; e = edge_n + 1;
    expect_ev(e + DTON, 1, 0, 0, "R4");
    wait_edge(e + DTON + 5);
    chan_en = 0; d = edge_n + 1;
    expect_ev(d, 0, 0, 0, "R5");
    expect_ev(d + DTOFF, 0, 0, 1, "R5");
    wait_edge(d + DTOFF + 100);
    chan_en = 1; e = edge_n + 1;
    expect_ev(e, 0, 0, 0, "R11");
    expect_ev(e + DTON, 1, 0, 0, "R11");
    wait_edge(e + DTON + 5);

    // R7: held drain, then R4 from draining, R10 abort during ramp
    drain_hold = 1; chan_en = 0; d = edge_n + 1;
    expect_ev(d, 0, 0, 0, "R5");
    expect_ev(d + DTOFF, 0, 0, 1, "R7");
    wait_edge(d + DTOFF + DIS * TCK + 200);
    check("R7", drain_on, 1);
    ramp_en = 1; ramp_sel = 2'd2; chan_en = 1; e = edge_n + 1;
    expect_ev(e, 0, 0, 0, "R4");
    expect_ev(e + DTON, 1, 1, 0, "R4");
    wait_edge(e + DTON + 100);
    chan_en = 0; d = edge_n + 1;
    expect_ev(d, 0, 0, 0, "R10");
    expect_ev(d + DTOFF, 0, 0, 1, "R7");
    wait_edge(d + 1);
    check("R10", ramp_level, 0);
    wait_edge(d + DTOFF + 10);

    // R12: undervoltage during drain, while enabled, and while on
    uvlo = 1; u = edge_n + 1;
    expect_ev(u, 0, 0, 0, "R12");
    wait_edge(u + 50);
    chan_en = 1;
    wait_edge(u + 250);
    check("R12", gate_on, 0);
    uvlo = 0; u = edge_n + 1;
    expect_ev(u + DTON, 1, 1, 0, "R12");
    expect_ev(u + DTON + 4 * BASE * TCK, 1, 0, 0, "R1");
    wait_edge(u + DTON + 4 * BASE * TCK + 5);
    uvlo = 1; u = edge_n + 1;
    expect_ev(u, 0, 0, 0, "R12");
    wait_edge(u + 50);
    check("R12", drain_on, 0);
    chan_en = 0; uvlo = 0;
    wait_edge(edge_n + 200);

    // R13: dedicated pin ORed into the enable
    drain_en = 0; ramp_en = 0; aux_en = 1; e = edge_n + 1;
    expect_ev(e + DTON, 1, 0, 0, "R13");
    wait_edge(e + DTON + 5);
    chan_en = 1; aux_en = 0;
    wait_edge(edge_n + 20);
    check("R13", gate_on, 1);
    chan_en = 0; d = edge_n + 1;
    expect_ev(d, 0, 0, 0, "R13");
    wait_edge(d + 100);

    check("R9", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule